// File: doc/BRIEF.md
# Paced Parallel Input Capture Controller

This block samples a parallel input word and hands it on through a valid/ready push port that feeds a FIFO. Three pacing sources are available. A pacer tick can be chosen from three incoming pulse trains. The rising edge of an external strobe can pace sampling. A request/acknowledge exchange with a peripheral can also pace it. The strobe and the handshake request share one input line, and the mode decides how that line is read.

Capture runs only while the enable input is high. If trigger gating is selected, capture also waits for a rising edge on the trigger line. Each sample is 8, 16 or 32 bits wide. Narrow samples are packed into full words with the earliest sample in the least significant bits, and a word is pushed only when it is complete. If a sample arrives while a finished word is still waiting for the consumer, the sample is dropped and a sticky overflow flag is raised.

Top module: `dcap_top`

## Requirements
- R1: During and immediately after reset, push_valid, ack_out and overflow are all low.
- R2: With mode code 0 (pacer), each cycle in which the pacer tick chosen by cfg_pace_sel is high captures one sample. Select code 0 picks tick_fast, 1 picks tick_half, 2 picks timer_tick and 3 picks nothing. Ticks that are not selected have no effect.
- R3: With mode code 1 (strobe), ext_req passes through a two-flop synchronizer. Each rising edge captures exactly one sample, however long the line stays high. Pacer ticks are ignored in this mode.
- R4: With mode code 2 (handshake), a rising edge of ext_req captures one sample, and ack_out goes high for exactly one cycle in the cycle after the capture. No further request is taken until ext_req has gone low again.
- R5: When cfg_trig_en is high, no sample is captured until a synchronized rising edge of ext_trig is seen while enabled. After that edge, capture continues for as long as cfg_enable stays high.
- R6: While cfg_enable is low, nothing is captured, a partly filled word is discarded and the trigger is re-armed.
- R7: Width code 0 takes din[7:0] and completes a word after four samples. Code 1 takes din[15:0] and completes a word after two samples. Codes 2 and 3 take all 32 bits, one word per sample. Sample k of a word occupies the bits starting at k times the sample width.
- R8: While push_valid is high and push_ready is low, push_valid stays high and push_data does not change.
- R9: A sample that arrives while a word is pending and push_ready is low is dropped, and overflow is set. Overflow stays set until an ovf_clear pulse clears it. A new drop in the same cycle as ovf_clear wins.
- R10: Mode code 3 captures nothing and never drives ack_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Capture enable; when low, clears the partial word and the trigger |
| cfg_mode | input | 2 | 0 pacer, 1 strobe, 2 handshake, 3 off |
| cfg_pace_sel | input | 2 | Pacer source: 0 fast, 1 half, 2 timer, 3 none |
| cfg_width | input | 2 | Sample width: 0 8-bit, 1 16-bit, 2 or 3 32-bit |
| cfg_trig_en | input | 1 | Wait for a trigger edge before capturing |
| ovf_clear | input | 1 | Clears the overflow flag |
| tick_fast | input | 1 | Fast pacer pulse, synchronous |
| tick_half | input | 1 | Half-rate pacer pulse, synchronous |
| timer_tick | input | 1 | Timer channel output pulse, synchronous |
| din | input | 32 | Parallel input data |
| ext_req | input | 1 | Asynchronous strobe / handshake request |
| ext_trig | input | 1 | Asynchronous start trigger |
| ack_out | output | 1 | Handshake acknowledge pulse |
| push_valid | output | 1 | Packed word is valid |
| push_ready | input | 1 | FIFO accepts the word |
| push_data | output | 32 | Packed word |
| overflow | output | 1 | Sticky dropped-sample flag |

## Verification
The bench builds the block with its defaults: a 32-bit bus, 8-bit lanes (four per word) and a two-stage synchronizer. These defaults make every packing depth reachable: four-sample bytes, two-sample halves and single full words. Packing is checked against bench-built expected words, and the latency of the synchronized strobe, request and trigger paths follows directly from the stage count. Holding push_ready low, with a word size of one sample, reaches the overflow path in two pacer ticks.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  typedef enum logic [1:0] {
    MODE_PACER  = 2'd0,
    MODE_STROBE = 2'd1,
    MODE_HSHAKE = 2'd2,
    MODE_OFF    = 2'd3
  } cap_mode_e;

  typedef enum logic [1:0] {
    PACE_FAST  = 2'd0,
    PACE_HALF  = 2'd1,
    PACE_TIMER = 2'd2,
    PACE_NONE  = 2'd3
  } pace_sel_e;

  typedef enum logic [1:0] {
    WID_8   = 2'd0,
    WID_16  = 2'd1,
    WID_32  = 2'd2,
    WID_32B = 2'd3
  } width_e;
endpackage

// File: rtl/dcap_sync_edge.sv
module dcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

  // R3: a detected edge can never repeat in the following cycle
  p_rise_single_r3: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/dcap_pace_mux.sv
module dcap_pace_mux
  import dcap_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] mode,
  input  logic [1:0] pace_sel,
  input  logic       tick_fast,
  input  logic       tick_half,
  input  logic       timer_tick,
  input  logic       req_rise,
  input  logic       req_level,
  output logic       sample_evt,
  output logic       ack_q
);
  logic pace_tick;
  logic hs_wait;
  logic hs_take;

  always_comb begin
    case (pace_sel_e'(pace_sel))
      PACE_FAST:  pace_tick = tick_fast;
      PACE_HALF:  pace_tick = tick_half;
      PACE_TIMER: pace_tick = timer_tick;
      default:    pace_tick = 1'b0;
    endcase
  end

  assign hs_take = run && (cap_mode_e'(mode) == MODE_HSHAKE) && req_rise && !hs_wait;

  always_comb begin
    case (cap_mode_e'(mode))
      MODE_PACER:  sample_evt = run & pace_tick;
      MODE_STROBE: sample_evt = run & req_rise;
      MODE_HSHAKE: sample_evt = hs_take;
      default:     sample_evt = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_wait <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= hs_take;
      if (hs_take)         hs_wait <= 1'b1;
      else if (!req_level) hs_wait <= 1'b0;
    end
  end

  // R4: acknowledge is a single-cycle pulse
  p_ack_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    ack_q |=> !ack_q);
  // R4: acknowledge follows a handshake-mode capture
  p_ack_after_take_r4: assert property (@(posedge clk) disable iff (rst)
    (sample_evt && cap_mode_e'(mode) == MODE_HSHAKE) |=> ack_q);
endmodule

// File: rtl/dcap_packer.sv
module dcap_packer
  import dcap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              sample_evt,
  input  logic [1:0]        width,
  input  logic [DATA_W-1:0] din,
  input  logic              ovf_clear,
  input  logic              push_ready,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic              overflow
);
  localparam int LANES  = DATA_W / LANE_W;
  localparam int IDX_W  = $clog2(LANES);
  localparam int POS_W  = IDX_W + 1;
  localparam int HALF_L = 16 / LANE_W;

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] merged;
  logic [POS_W-1:0]  pos;
  logic [POS_W-1:0]  n_add;
  logic [POS_W-1:0]  pos_sum;
  logic              slot_free;
  logic              accept;
  logic              drop;
  logic              full;
  logic [LANE_W-1:0] din_l [LANES];

  always_comb begin
    case (width_e'(width))
      WID_8:   n_add = POS_W'(1);
      WID_16:  n_add = POS_W'(HALF_L);
      default: n_add = POS_W'(LANES);
    endcase
  end

  // place the new sample's lanes above those already collected
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [POS_W-1:0] rel;
    assign din_l[i] = din[i*LANE_W +: LANE_W];
    assign rel = POS_W'(i) - pos;
    assign merged[i*LANE_W +: LANE_W] =
      (POS_W'(i) >= pos && rel < n_add) ? din_l[rel[IDX_W-1:0]]
                                        : acc[i*LANE_W +: LANE_W];
  end

  assign pos_sum   = pos + n_add;
  assign full      = pos_sum >= POS_W'(LANES);
  assign slot_free = !push_valid || push_ready;
  assign accept    = sample_evt && slot_free;
  assign drop      = sample_evt && !slot_free;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc        <= '0;
      pos        <= '0;
      push_valid <= 1'b0;
      push_data  <= '0;
      overflow   <= 1'b0;
    end else begin
      if (push_valid && push_ready) push_valid <= 1'b0;
      if (flush) begin
        acc <= '0;
        pos <= '0;
      end else if (accept) begin
        if (full) begin
          push_data  <= merged;
          push_valid <= 1'b1;
          acc        <= '0;
          pos        <= '0;
        end else begin
          acc <= merged;
          pos <= pos_sum;
        end
      end
      if (drop)           overflow <= 1'b1;
      else if (ovf_clear) overflow <= 1'b0;
    end
  end

  // R8: a pending word is held until taken
  p_hold_word_r8: assert property (@(posedge clk) disable iff (rst)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_data)));
  // R9: overflow is sticky without a clear
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clear) |=> overflow);
  // R9: a dropped sample raises the flag
  p_drop_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (sample_evt && push_valid && !push_ready) |=> overflow);
endmodule

// File: rtl/dcap_top.sv
module dcap_top
  import dcap_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LANE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_pace_sel,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_trig_en,
  input  logic              ovf_clear,
  input  logic              tick_fast,
  input  logic              tick_half,
  input  logic              timer_tick,
  input  logic [DATA_W-1:0] din,
  input  logic              ext_req,
  input  logic              ext_trig,
  output logic              ack_out,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [DATA_W-1:0] push_data,
  output logic              overflow
);
  logic req_level, req_rise;
  logic trig_level, trig_rise;
  logic trig_seen;
  logic run;
  logic sample_evt;

  dcap_sync_edge #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk(clk), .rst(rst), .async_in(ext_req), .level(req_level), .rise(req_rise)
  );

  dcap_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk(clk), .rst(rst), .async_in(ext_trig), .level(trig_level), .rise(trig_rise)
  );

  always_ff @(posedge clk) begin
    if (rst || !cfg_enable) trig_seen <= 1'b0;
    else if (trig_rise)     trig_seen <= 1'b1;
  end

  assign run = cfg_enable && (!cfg_trig_en || trig_seen);

  dcap_pace_mux u_pace (
    .clk(clk), .rst(rst), .run(run), .mode(cfg_mode), .pace_sel(cfg_pace_sel),
    .tick_fast(tick_fast), .tick_half(tick_half), .timer_tick(timer_tick),
    .req_rise(req_rise), .req_level(req_level),
    .sample_evt(sample_evt), .ack_q(ack_out)
  );

  dcap_packer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_pack (
    .clk(clk), .rst(rst), .flush(!cfg_enable), .sample_evt(sample_evt),
    .width(cfg_width), .din(din), .ovf_clear(ovf_clear), .push_ready(push_ready),
    .push_valid(push_valid), .push_data(push_data), .overflow(overflow)
  );

  // R5: nothing is sampled before the trigger when gating is on
  p_trig_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_trig_en && !trig_seen) |-> !sample_evt);
  // R6: disabled block samples nothing
  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |-> !sample_evt);
  // R10: off mode samples nothing
  p_mode_off_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd3) |-> !sample_evt);
  // R1: outputs are quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!push_valid && !ack_out && !overflow));
endmodule

// File: tb/dcap_top_tb_top.sv
`timescale 1ns/1ps
module dcap_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_pace_sel = 2'd0;
  logic [1:0]  cfg_width = 2'd2;
  logic        cfg_trig_en = 1'b0;
  logic        ovf_clear = 1'b0;
  logic        tick_fast = 1'b0, tick_half = 1'b0, timer_tick = 1'b0;
  logic [31:0] din = '0;
  logic        ext_req = 1'b0, ext_trig = 1'b0;
  logic        ack_out, push_valid, push_ready = 1'b1, overflow;
  logic [31:0] push_data;

  int checks = 0, failures = 0;
  int ng = 0, acks = 0, ack_dbl = 0;
  logic [31:0] got [64];
  logic prev_ack = 1'b0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  dcap_top dut_i (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
    .cfg_pace_sel(cfg_pace_sel), .cfg_width(cfg_width), .cfg_trig_en(cfg_trig_en),
    .ovf_clear(ovf_clear), .tick_fast(tick_fast), .tick_half(tick_half),
    .timer_tick(timer_tick), .din(din), .ext_req(ext_req), .ext_trig(ext_trig),
    .ack_out(ack_out), .push_valid(push_valid), .push_ready(push_ready),
    .push_data(push_data), .overflow(overflow)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (push_valid && push_ready) begin
        if (ng < 64) got[ng] = push_data;
        ng++;
      end
      if (ack_out) acks++;
      if (ack_out && prev_ack) ack_dbl++;
      prev_ack = ack_out;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int which, input logic [31:0] d);
    @(negedge clk);
    din = d;
    tick_fast  = (which == 0);
    tick_half  = (which == 1);
    timer_tick = (which == 2);
    @(negedge clk);
    tick_fast = 0; tick_half = 0; timer_tick = 0;
  endtask

  task automatic req_pulse(input logic [31:0] d, input int hi, input int lo);
    @(negedge clk);
    din = d;
    ext_req = 1'b1;
    idle(hi);
    ext_req = 1'b0;
    idle(lo);
  endtask

  task automatic setup(input logic [1:0] mode, input logic [1:0] ps, input logic [1:0] w, input logic te);
    @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
    cfg_mode = mode; cfg_pace_sel = ps; cfg_width = w; cfg_trig_en = te;
    cfg_enable = 1;
  endtask

  task automatic t_reset();
    idle(1);
    chk(!push_valid && !ack_out && !overflow, "R1 reset outputs",
        {29'd0, push_valid, ack_out, overflow}, 32'd0);
    rst = 0;
    idle(2);
    chk(!push_valid && !ack_out && !overflow, "R1 after reset",
        {29'd0, push_valid, ack_out, overflow}, 32'd0);
  endtask

  task automatic t_pacer();
    int base;
    setup(2'd0, 2'd1, 2'd0, 1'b0);
    base = ng;
    tick(0, 32'h000000EE);
    tick(2, 32'h000000EE);
    idle(3);
    chk(ng == base && !push_valid, "R2 unselected ticks ignored", ng - base, 0);
    tick(1, 32'hAAAAAA11);
    tick(1, 32'hBBBBBB22);
    tick(1, 32'hCCCCCC33);
    tick(1, 32'hDDDDDD44);
    idle(3);
    chk(ng == base + 1, "R2 one word from four half ticks", ng - base, 1);
    chk(got[base] == 32'h44332211, "R7 byte packing little-endian", got[base], 32'h44332211);
    setup(2'd0, 2'd2, 2'd2, 1'b0);
    base = ng;
    tick(2, 32'h12345678);
    idle(3);
    chk(ng == base + 1 && got[base] == 32'h12345678, "R2 timer tick 32-bit",
        got[base], 32'h12345678);
  endtask

  task automatic t_strobe();
    int base;
    setup(2'd1, 2'd0, 2'd1, 1'b0);
    base = ng;
    tick(0, 32'h0);
    tick(0, 32'h0);
    idle(3);
    chk(ng == base, "R3 ticks ignored in strobe mode", ng - base, 0);
    req_pulse(32'h1111AAAA, 8, 6);
    req_pulse(32'h2222BBBB, 8, 6);
    chk(ng == base + 1, "R3 one capture per edge", ng - base, 1);
    chk(got[base] == 32'hBBBBAAAA, "R7 half packing", got[base], 32'hBBBBAAAA);
    chk(acks == 0, "R3 no acknowledge outside handshake", acks, 0);
  endtask

  task automatic t_hshake();
    int base, a0;
    setup(2'd2, 2'd0, 2'd2, 1'b0);
    base = ng; a0 = acks;
    req_pulse(32'hCAFE0001, 12, 6);
    chk(ng == base + 1 && got[base] == 32'hCAFE0001, "R4 first request captured once",
        ng - base, 1);
    chk(acks == a0 + 1, "R4 one ack per request", acks - a0, 1);
    req_pulse(32'hCAFE0002, 3, 6);
    chk(ng == base + 2 && got[base+1] == 32'hCAFE0002, "R4 re-request after release",
        got[base+1], 32'hCAFE0002);
    chk(ack_dbl == 0 && acks == a0 + 2, "R4 ack single-cycle pulses", ack_dbl, 0);
  endtask

  task automatic t_trigger();
    int base;
    setup(2'd0, 2'd0, 2'd2, 1'b1);
    base = ng;
    tick(0, 32'h0BAD0BAD);
    idle(3);
    chk(ng == base, "R5 gated before trigger", ng - base, 0);
    @(negedge clk); ext_trig = 1;
    idle(5); ext_trig = 0;
    idle(2);
    tick(0, 32'h600D600D);
    idle(3);
    chk(ng == base + 1 && got[base] == 32'h600D600D, "R5 capture after trigger",
        got[base], 32'h600D600D);
    setup(2'd0, 2'd0, 2'd2, 1'b1);
    base = ng;
    tick(0, 32'h0BAD0BAD);
    idle(3);
    chk(ng == base, "R6 trigger re-armed by disable", ng - base, 0);
  endtask

  task automatic t_enable();
    int base;
    setup(2'd0, 2'd0, 2'd0, 1'b0);
    base = ng;
    tick(0, 32'h000000F1);
    tick(0, 32'h000000F2);
    @(negedge clk); cfg_enable = 0;
    tick(0, 32'h000000F3);
    idle(2);
    @(negedge clk); cfg_enable = 1;
    tick(0, 32'h00000001);
    tick(0, 32'h00000002);
    tick(0, 32'h00000003);
    tick(0, 32'h00000004);
    idle(3);
    chk(ng == base + 1 && got[base] == 32'h04030201, "R6 partial word discarded",
        got[base], 32'h04030201);
  endtask

  task automatic t_overflow();
    int base;
    setup(2'd0, 2'd0, 2'd2, 1'b0);
    base = ng;
    @(negedge clk); push_ready = 0;
    tick(0, 32'hA0A0A0A0);
    idle(2);
    chk(push_valid && push_data == 32'hA0A0A0A0 && !overflow, "R8 word pending",
        push_data, 32'hA0A0A0A0);
    tick(0, 32'hB1B1B1B1);
    idle(1);
    chk(overflow, "R9 overflow set on drop", overflow, 1);
    chk(push_data == 32'hA0A0A0A0, "R8 pending data held", push_data, 32'hA0A0A0A0);
    @(negedge clk); push_ready = 1;
    idle(3);
    chk(ng == base + 1 && got[base] == 32'hA0A0A0A0, "R9 dropped sample not pushed",
        ng - base, 1);
    chk(overflow, "R9 overflow sticky", overflow, 1);
    @(negedge clk); ovf_clear = 1;
    @(negedge clk); ovf_clear = 0;
    idle(1);
    chk(!overflow, "R9 overflow cleared", overflow, 0);
  endtask

  task automatic t_off();
    int base, a0;
    setup(2'd3, 2'd0, 2'd2, 1'b0);
    base = ng; a0 = acks;
    tick(0, 32'h1);
    req_pulse(32'h2, 6, 6);
    chk(ng == base && acks == a0, "R10 off mode inert", ng - base, 0);
  endtask

  initial begin
    t_reset();
    t_pacer();
    t_strobe();
    t_hshake();
    t_trigger();
    t_enable();
    t_overflow();
    t_off();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule